// File: doc/BRIEF.md
# Host Parallel Read Port with Receive-FIFO Alias

This block is the read side of a 16-bit asynchronous host bus on a network controller, modelled in the controller's clock domain. The host drives an active-low chip select, an active-low read strobe, an 8-bit byte address and a FIFO-select line. The block synchronises the two strobes, detects the start and the end of each access from their combined level, decodes the address and returns either an internal register word or the head word of the receive data FIFO. It drives the enable for the external tri-state data buffer while an access is in progress.

With FIFO-select high, the upper address bits are not decoded, and only address bits [2:1] choose a word inside a small four-word window that holds the FIFO data port and a status word. A host that must increment its address on every bus cycle can then stream the receive FIFO in one burst. The FIFO is popped exactly once for each completed access to its data port. A read of an empty FIFO returns zero and sets a sticky underrun flag that the host can read.

Top module: `host_pio_rd`

## Requirements
- R1: While rst_ni is low and after it is released with no access, data_oe_o is 0, fifo_pop_o is 0 and data_o is 0.
- R2: An access starts only when both cs_ni and rd_ni are low. If both are first seen low at rising edge n, data_oe_o is 1 and data_o carries the read word after edge n+2.
- R3: An access ends as soon as either strobe is high. If that is first seen at rising edge m, data_oe_o falls at edge m+2, and a FIFO data access pulses fifo_pop_o for exactly the one cycle after edge m+2.
- R4: Behaviour does not depend on the order in which the two strobes are asserted or released.
- R5: With fifo_sel_i = 1, addr_i[7:3] is ignored. Window words 0 and 1 (addr_i[2:1] = 00 or 01) return the FIFO head word and pop the FIFO.
- R6: Window word 2 (addr_i[2:1] = 10) is the status word: bit 0 is the sticky underrun flag, bit 1 is fifo_empty_i at the start of the access, and the other bits are 0. A completed status read clears the underrun flag. Window word 3 reads 0 and does not pop.
- R7: With fifo_sel_i = 0, the word index is addr_i[7:1]. Indexes 0 to 3 are the same window as in R5 and R6, indexes 4 to 4+NUM_REGS-1 return reg_words_i word (index-4), and every other index reads 0.
- R8: A FIFO data access while fifo_empty_i is 1 returns 0, does not pop, and sets the underrun flag.
- R9: A strobe assertion that falls entirely between two rising edges does not start an access, assert data_oe_o or pop the FIFO.
- R10: data_o holds its value for the whole access, even if fifo_data_i changes after the start.
- R11: Register, status and unmapped reads never pop, and each FIFO data access pops exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Host chip select, active low, asynchronous |
| rd_ni | input | 1 | Host read strobe, active low, asynchronous |
| addr_i | input | AW (8) | Host byte address |
| fifo_sel_i | input | 1 | High selects the receive-FIFO alias window |
| reg_words_i | input | NUM_REGS*DW (64) | Register words, word k at bits [k*DW +: DW] |
| fifo_data_i | input | DW (16) | Receive FIFO head word (show-ahead) |
| fifo_empty_i | input | 1 | Receive FIFO is empty |
| fifo_pop_o | output | 1 | Single-cycle pop of the receive FIFO |
| data_o | output | DW (16) | Read data toward the host bus buffer |
| data_oe_o | output | 1 | Host data buffer output enable |

## Verification
Every result is due a fixed number of edges after the strobes change: the two synchroniser flops and the activity register put data and enable on the second edge after the one that first sees both strobes low, and the end of the access does the same for the enable drop and the pop pulse. The bench changes inputs on falling edges, waits three rising edges and samples on the next falling edge, so each check lands in the cycle the requirement names. It counts pops on every rising edge, so a missing, late or duplicate pop shows up as a wrong count. The head word is corrupted during every active access to show that the returned word is held.

// File: rtl/host_pio_pkg.sv
package host_pio_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_FIFO = 2'd1,
    TGT_STAT = 2'd2,
    TGT_REG  = 2'd3
  } rd_tgt_e;

  localparam int WIN_FIFO_LO = 0;
  localparam int WIN_FIFO_HI = 1;
  localparam int WIN_STAT    = 2;
  localparam int REG_BASE    = 4;
  localparam int STAT_UNDR_BIT  = 0;
  localparam int STAT_EMPTY_BIT = 1;
endpackage

// File: rtl/pio_strobe_sync.sv
module pio_strobe_sync #(
  parameter int STAGES = 2,
  parameter int NBITS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBITS-1:0] strb_ni,
  output logic [NBITS-1:0] strb_no
);
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-2:0], strb_ni[b]};
    end
    assign strb_no[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/pio_cycle_ctl.sv
module pio_cycle_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_sn_i,
  input  logic rd_sn_i,
  output logic start_o,
  output logic end_o,
  output logic active_o
);
  logic act;
  logic act_q;

  assign act = ~cs_sn_i & ~rd_sn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  assign start_o  = act & ~act_q;
  assign end_o    = ~act & act_q;
  assign active_o = act_q;
endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
  import host_pio_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int NUM_REGS = 4
) (
  input  logic [AW-1:0]          addr_i,
  input  logic                   fifo_sel_i,
  input  logic [NUM_REGS*DW-1:0] reg_words_i,
  input  logic [DW-1:0]          fifo_data_i,
  input  logic                   fifo_empty_i,
  input  logic                   underrun_i,
  output logic [DW-1:0]          rdata_o,
  output rd_tgt_e                tgt_o
);
  localparam int IW = AW - 1;

  logic [IW-1:0] idx;

  // alias mode keeps only the two low word bits
  assign idx = fifo_sel_i ? IW'(addr_i[2:1]) : addr_i[AW-1:1];

  always_comb begin
    rdata_o = '0;
    tgt_o   = TGT_NONE;
    if (idx == IW'(WIN_FIFO_LO) || idx == IW'(WIN_FIFO_HI)) begin
      tgt_o   = TGT_FIFO;
      rdata_o = fifo_empty_i ? '0 : fifo_data_i;
    end else if (idx == IW'(WIN_STAT)) begin
      tgt_o                   = TGT_STAT;
      rdata_o[STAT_UNDR_BIT]  = underrun_i;
      rdata_o[STAT_EMPTY_BIT] = fifo_empty_i;
    end else begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (idx == IW'(REG_BASE + k)) begin
          tgt_o   = TGT_REG;
          rdata_o = reg_words_i[k*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/host_pio_rd.sv
module host_pio_rd
  import host_pio_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   rd_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic                   fifo_sel_i,
  input  logic [NUM_REGS*DW-1:0] reg_words_i,
  input  logic [DW-1:0]          fifo_data_i,
  input  logic                   fifo_empty_i,
  output logic                   fifo_pop_o,
  output logic [DW-1:0]          data_o,
  output logic                   data_oe_o
);
  logic [1:0] strb_s;
  logic       cyc_start, cyc_end, cyc_active;
  logic [DW-1:0] rdata;
  rd_tgt_e    tgt;

  logic [DW-1:0] data_q;
  logic       pop_pend_q, stat_rd_q, underrun_q, pop_q;

  pio_strobe_sync #(.STAGES(SYNC_STAGES), .NBITS(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strb_ni ({rd_ni, cs_ni}),
    .strb_no (strb_s)
  );

  pio_cycle_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_sn_i  (strb_s[0]),
    .rd_sn_i  (strb_s[1]),
    .start_o  (cyc_start),
    .end_o    (cyc_end),
    .active_o (cyc_active)
  );

  pio_read_mux #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS)) u_mux (
    .addr_i       (addr_i),
    .fifo_sel_i   (fifo_sel_i),
    .reg_words_i  (reg_words_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_empty_i (fifo_empty_i),
    .underrun_i   (underrun_q),
    .rdata_o      (rdata),
    .tgt_o        (tgt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q     <= '0;
      pop_pend_q <= 1'b0;
      stat_rd_q  <= 1'b0;
      underrun_q <= 1'b0;
      pop_q      <= 1'b0;
    end else begin
      pop_q <= 1'b0;
      if (cyc_start) begin
        data_q     <= rdata;
        pop_pend_q <= (tgt == TGT_FIFO) && !fifo_empty_i;
        stat_rd_q  <= (tgt == TGT_STAT);
        if (tgt == TGT_FIFO && fifo_empty_i) underrun_q <= 1'b1;
      end else if (cyc_end) begin
        pop_q      <= pop_pend_q;
        pop_pend_q <= 1'b0;
        stat_rd_q  <= 1'b0;
        if (stat_rd_q) underrun_q <= 1'b0;
      end
    end
  end

  assign data_o     = data_q;
  assign data_oe_o  = cyc_active;
  assign fifo_pop_o = pop_q;
endmodule

// File: rtl/host_pio_rd_chk.sv
module host_pio_rd_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          rd_ni,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o,
  input logic          fifo_pop_o,
  input logic          underrun_q
);
  AST_OE_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(!cs_ni && !rd_ni, 2)); // R2

  AST_OE_DROP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_oe_o) |-> $past(cs_ni || rd_ni, 2)); // R3

  AST_POP_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> $fell(data_oe_o)); // R3

  AST_POP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o); // R11

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o)); // R10

  AST_UNDR_CLR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(underrun_q) |-> $fell(data_oe_o)); // R6

  AST_UNDR_SET_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_q) |-> $rose(data_oe_o)); // R8
endmodule

bind host_pio_rd host_pio_rd_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .rd_ni      (rd_ni),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .fifo_pop_o (fifo_pop_o),
  .underrun_q (underrun_q)
);

// File: tb/host_pio_rd_test.sv
`timescale 1ns/1ps
module host_pio_rd_test;
  localparam int AW = 8, DW = 16, NR = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic fifo_sel_i = 1'b0;
  logic [NR*DW-1:0] reg_words_i;
  logic [DW-1:0] fifo_data_i;
  logic fifo_empty_i, fifo_pop_o, data_oe_o;
  logic [DW-1:0] data_o;

  logic [DW-1:0] fmem [8];
  int fptr = 0, fcnt = 0, pops = 0;
  logic [DW-1:0] fxor = '0;
  int tests = 0, fails = 0;
  bit oe_seen = 1'b0;

  always #2 clk_i = ~clk_i;

  for (genvar k = 0; k < NR; k++) begin : g_regs
    assign reg_words_i[k*DW +: DW] = 16'hA0A0 + 16'(k);
  end

  assign fifo_empty_i = (fcnt == 0);
  assign fifo_data_i  = ((fcnt != 0) ? fmem[fptr] : 16'hDEAD) ^ fxor;

  always @(posedge clk_i) begin
    if (fifo_pop_o) begin
      pops <= pops + 1;
      if (fcnt != 0) begin
        fptr <= fptr + 1;
        fcnt <= fcnt - 1;
      end
    end
    if (data_oe_o) oe_seen <= 1'b1;
  end

  host_pio_rd uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // order: bit0 = assert rd first, bit1 = release rd first
  task automatic do_read(input logic [7:0] a, input bit sel, input bit [1:0] order,
                         input logic [DW-1:0] exp, input bit exp_pop, input string req);
    int p0;
    @(negedge clk_i);
    addr_i = a; fifo_sel_i = sel;
    if (order[0]) rd_ni = 1'b0; else cs_ni = 1'b0;
    @(negedge clk_i);
    if (order[0]) cs_ni = 1'b0; else rd_ni = 1'b0;
    p0 = pops;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(data_oe_o === 1'b1, {req, " R2 oe"}, 32'(data_oe_o), 1);
    chk(data_o === exp, {req, " R2 data"}, 32'(data_o), 32'(exp));
    fxor = 16'hFFFF;
    repeat (2) @(negedge clk_i);
    chk(data_o === exp, {req, " R10 hold"}, 32'(data_o), 32'(exp));
    fxor = '0;
    if (order[1]) rd_ni = 1'b1; else cs_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(data_oe_o === 1'b0, {req, " R3 oe off"}, 32'(data_oe_o), 0);
    chk(fifo_pop_o === exp_pop, {req, " R3 pop pulse"}, 32'(fifo_pop_o), 32'(exp_pop));
    cs_ni = 1'b1; rd_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(pops - p0 == int'(exp_pop), {req, " R11 pop count"}, 32'(pops - p0), 32'(exp_pop));
  endtask

  task automatic t_reset();
    #1;
    chk(data_oe_o === 1'b0 && fifo_pop_o === 1'b0 && data_o === '0, "R1 in reset",
        {data_oe_o, fifo_pop_o, data_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(data_oe_o === 1'b0 && fifo_pop_o === 1'b0 && data_o === '0, "R1 after reset",
        {data_oe_o, fifo_pop_o, data_o}, 0);
  endtask

  task automatic t_glitch();
    int p0;
    p0 = pops;
    @(negedge clk_i);
    oe_seen = 1'b0;
    @(posedge clk_i);
    #0.5 cs_ni = 1'b0; rd_ni = 1'b0;
    #1   cs_ni = 1'b1; rd_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    chk(!oe_seen, "R9 no oe", 32'(oe_seen), 0);
    chk(pops == p0, "R9 no pop", 32'(pops - p0), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) fmem[i] = 16'hC000 + 16'(i);
    fcnt = 3;
    t_reset();
    do_read(8'h08, 1'b0, 2'b00, 16'hA0A0, 1'b0, "R7 reg4");
    do_read(8'h0E, 1'b0, 2'b01, 16'hA0A3, 1'b0, "R4 R7 reg7 rd-first");
    do_read(8'h40, 1'b0, 2'b10, 16'h0000, 1'b0, "R7 unmapped");
    do_read(8'hF8, 1'b1, 2'b11, 16'hC000, 1'b1, "R5 alias w0");
    do_read(8'hAA, 1'b1, 2'b00, 16'hC001, 1'b1, "R5 alias w1");
    do_read(8'hFE, 1'b1, 2'b01, 16'h0000, 1'b0, "R6 alias w3");
    do_read(8'h00, 1'b0, 2'b10, 16'hC002, 1'b1, "R7 fifo direct");
    t_glitch();
    do_read(8'h81, 1'b1, 2'b00, 16'h0000, 1'b0, "R8 empty");
    do_read(8'h7C, 1'b1, 2'b00, 16'h0003, 1'b0, "R6 status set");
    do_read(8'h04, 1'b0, 2'b11, 16'h0002, 1'b0, "R6 status cleared");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule